// File: doc/BRIEF.md
# Programmable Horizontal Sync Pulse Generator

This block produces a horizontal sync output for a video path that carries its timing inside the data stream as four-byte reference codes. It watches the 8-bit byte stream for the code that marks end of active video and uses it to align a per-line position counter. It then drives a sync pulse whose leading and trailing edges sit at two programmable counter positions. Each position is an 11-bit value in pixel-clock units.

The line length is an input. Both edge positions wrap modulo that length, so the pulse can be placed on either side of active video. To move the pulse later by N, add N to both positions. To move it earlier by N, add (line length − N) to both. Output polarity is selectable. A clock enable qualifies every cycle, which lets the block run from a faster clock than the pixel rate.

Top module: `hsync_gen`

## Requirements
- R1: A byte sequence FF, 00, 00, XY taken on four consecutive enabled cycles, with XY bit 4 equal to 1 (end of active video), makes the counter read position 0 on the next enabled cycle after the XY byte.
- R2: When the XY byte has bit 4 equal to 0 (start of active video), the counter is not reset and keeps advancing.
- R3: The internal pulse becomes active at the enabled clock edge that ends position `hs_begin`. It becomes inactive at the enabled edge that ends position `hs_end`. The pulse therefore shows at positions `hs_begin`+1 through `hs_end`.
- R4: When `hs_end` is numerically smaller than `hs_begin`, the pulse runs across the line boundary and ends at `hs_end` in the following line.
- R5: When no end-of-active-video code arrives, the counter returns to 0 after position `line_len`−1, so the pulse repeats with a period of `line_len` enabled cycles.
- R6: With `hs_invert` = 0 the output is high while the pulse is active. With `hs_invert` = 1 the output is low while the pulse is active.
- R7: After reset, the pulse stays inactive until the first end-of-active-video code has been detected.
- R8: On cycles where `ce` is low, the block ignores the data byte and holds the counter and pulse state.
- R9: When `hs_begin` equals `hs_end`, the trailing edge wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; the block advances only when this is high |
| din | input | 8 | Video byte stream with embedded timing codes |
| hs_begin | input | 11 | Counter position at which the pulse starts |
| hs_end | input | 11 | Counter position at which the pulse ends |
| hs_invert | input | 1 | Output polarity: 0 active high, 1 active low |
| line_len | input | 11 | Total counts per line (at least 2) |
| hs_out | output | 1 | Horizontal sync output |

## Verification
The counter reads 0 one enabled edge after the XY byte is taken. The output changes one enabled edge after the counter equals `hs_begin` or `hs_end`. The polarity input acts on the output in the same cycle.

The bench updates a behavioural reference at each rising edge from the inputs held since the previous falling edge. It compares `hs_out` with that reference at every falling edge, so each result is checked in the cycle it is due. Directed checks count enabled bytes after an XY byte and sample exactly at positions `hs_begin` and `hs_begin`+1, and at `hs_end` and `hs_end`+1.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    // Progress through a timing reference prefix
    typedef enum logic [1:0] {
        TRS_IDLE,
        TRS_LEAD,
        TRS_ZERO1,
        TRS_ZERO2
    } trs_state_e;

    localparam logic [7:0] TRS_LEAD_BYTE = 8'hFF;
    localparam logic [7:0] TRS_ZERO_BYTE = 8'h00;
    localparam int         H_FLAG_BIT    = 4;

    // Flags raised by the reference detector
    typedef struct packed {
        logic hdr_done;   // three-byte prefix has been seen
        logic eav_hit;    // current byte completes an end-of-active code
    } trs_flags_t;

    function automatic trs_state_e trs_step(input trs_state_e cur, input logic [7:0] b);
        trs_state_e nxt;
        if (b == TRS_LEAD_BYTE) begin
            nxt = TRS_LEAD;
        end else begin
            unique case (cur)
                TRS_LEAD:  nxt = (b == TRS_ZERO_BYTE) ? TRS_ZERO1 : TRS_IDLE;
                TRS_ZERO1: nxt = (b == TRS_ZERO_BYTE) ? TRS_ZERO2 : TRS_IDLE;
                default:   nxt = TRS_IDLE;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/hsg_trs_detect.sv
module hsg_trs_detect
    import hsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic [7:0] din,
    output trs_flags_t flags
);

    trs_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRS_IDLE;
        end else if (ce) begin
            state_q <= trs_step(state_q, din);
        end
    end

    always_comb begin
        flags.hdr_done = (state_q == TRS_ZERO2);
        flags.eav_hit  = ce && (state_q == TRS_ZERO2) && din[H_FLAG_BIT];
    end

endmodule

// File: rtl/hsg_line_counter.sv
module hsg_line_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         restart,
    input  logic [W-1:0] line_len,
    output logic [W-1:0] cnt,
    output logic         synced
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] last_pos;
    assign last_pos = line_len - ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            synced <= 1'b0;
        end else if (ce) begin
            if (restart || cnt == last_pos) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
            if (restart) begin
                synced <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsg_pulse.sv
module hsg_pulse #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         synced,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] hs_begin,
    input  logic [W-1:0] hs_end,
    input  logic         hs_invert,
    output logic         active,
    output logic         hs_out
);

    logic at_begin;
    logic at_end;

    assign at_begin = (cnt == hs_begin);
    assign at_end   = (cnt == hs_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (ce && synced) begin
            if (at_end) begin
                active <= 1'b0;
            end else if (at_begin) begin
                active <= 1'b1;
            end
        end
    end

    assign hs_out = active ^ hs_invert;

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
    import hsg_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [7:0]       din,
    input  logic [CNT_W-1:0] hs_begin,
    input  logic [CNT_W-1:0] hs_end,
    input  logic             hs_invert,
    input  logic [CNT_W-1:0] line_len,
    output logic             hs_out
);

    trs_flags_t       flags;
    logic             eav_hit;
    logic             hdr_seen;
    logic [CNT_W-1:0] cnt;
    logic             synced;
    logic             active;

    assign eav_hit  = flags.eav_hit;
    assign hdr_seen = flags.hdr_done;

    hsg_trs_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .din   (din),
        .flags (flags)
    );

    hsg_line_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .restart  (eav_hit),
        .line_len (line_len),
        .cnt      (cnt),
        .synced   (synced)
    );

    hsg_pulse #(.W(CNT_W)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .synced    (synced),
        .cnt       (cnt),
        .hs_begin  (hs_begin),
        .hs_end    (hs_end),
        .hs_invert (hs_invert),
        .active    (active),
        .hs_out    (hs_out)
    );

endmodule

// File: rtl/hsg_checker.sv
module hsg_checker
    import hsg_pkg::*;
#(
    parameter int W = 11
) (
    input logic         clk,
    input logic         rst,
    input logic         ce,
    input logic [7:0]   din,
    input logic [W-1:0] hs_begin,
    input logic [W-1:0] hs_end,
    input logic         hs_invert,
    input logic [W-1:0] line_len,
    input logic         hs_out,
    input logic [W-1:0] cnt,
    input logic         synced,
    input logic         active,
    input logic         eav_hit,
    input logic         hdr_seen
);

    logic [W-1:0] last_pos;
    assign last_pos = line_len - W'(1);

    p_zero_after_eav_r1: assert property (@(posedge clk) disable iff (rst)
        (ce && hdr_seen && din[H_FLAG_BIT]) |=> (cnt == '0));

    p_sav_no_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (ce && hdr_seen && !din[H_FLAG_BIT] && cnt != last_pos) |=> (cnt == $past(cnt) + W'(1)));

    p_rise_at_begin_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && synced && cnt == hs_begin && cnt != hs_end) |=> active);

    p_fall_at_end_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && cnt == hs_end) |=> !active);

    p_wrap_free_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && !eav_hit && cnt == last_pos) |=> (cnt == '0));

    p_idle_before_sync_r7: assert property (@(posedge clk) disable iff (rst)
        !synced |-> (hs_out == hs_invert));

    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(cnt) && $stable(active) && $stable(synced)));

    p_equal_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (ce && hs_begin == hs_end && cnt == hs_begin) |=> !active);

endmodule

bind hsync_gen hsg_checker #(.W(CNT_W)) u_hsg_checker (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .din       (din),
    .hs_begin  (hs_begin),
    .hs_end    (hs_end),
    .hs_invert (hs_invert),
    .line_len  (line_len),
    .hs_out    (hs_out),
    .cnt       (cnt),
    .synced    (synced),
    .active    (active),
    .eav_hit   (eav_hit),
    .hdr_seen  (hdr_seen)
);

// File: tb/test_hsync_gen.sv
`timescale 1ns/1ps
module test_hsync_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic [7:0]  din = 8'h80;
    logic [10:0] hs_begin = 11'd2;
    logic [10:0] hs_end = 11'd0;
    logic        hs_invert = 1'b0;
    logic [10:0] line_len = 11'd20;
    logic        hs_out;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R7";
    bit    gap_mode = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    always #2.5 clk = ~clk;

    hsync_gen i_hsync_gen (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .din       (din),
        .hs_begin  (hs_begin),
        .hs_end    (hs_end),
        .hs_invert (hs_invert),
        .line_len  (line_len),
        .hs_out    (hs_out)
    );

    // Behavioural reference: position, sync seen, pulse state, last enabled bytes
    int         m_pos = 0;
    bit         m_sync = 1'b0;
    bit         m_act = 1'b0;
    bit         m_eav;
    logic [7:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0;
            m_sync = 1'b0;
            m_act = 1'b0;
            hist.delete();
        end else if (ce) begin
            m_eav = (hist.size() == 3) && hist[0] == 8'hFF && hist[1] == 8'h00 &&
                    hist[2] == 8'h00 && din[4];
            if (m_sync) begin
                if (m_pos == int'(hs_end)) m_act = 1'b0;
                else if (m_pos == int'(hs_begin)) m_act = 1'b1;
            end
            if (m_eav || m_pos == int'(line_len) - 1) m_pos = 0;
            else m_pos = m_pos + 1;
            if (m_eav) m_sync = 1'b1;
            hist.push_back(din);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: hs_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        check(cur_req, hs_out, m_act ^ hs_invert);
    end

    task automatic put(input logic [7:0] b);
        int gaps;
        if (gap_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            gaps = int'(lfsr[1:0]);
            for (int i = 0; i < gaps; i++) begin
                ce = 1'b0;
                din = 8'hFF;      // junk while disabled must be ignored (R8)
                @(negedge clk);
            end
        end
        ce = 1'b1;
        din = b;
        @(negedge clk);
    endtask

    task automatic send_code(input logic [7:0] xy);
        put(8'hFF);
        put(8'h00);
        put(8'h00);
        put(xy);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) put(8'h80);
    endtask

    task automatic send_line(input int len);
        fill(len - 4);
        send_code(8'hF1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog: done=0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: reset state and no pulse before the first end-of-active code
        repeat (3) @(negedge clk);
        check("R7 reset", hs_out, 1'b0);
        rst = 1'b0;
        hs_begin = 11'd2;
        hs_end = 11'd6;
        fill(45);
        check("R7 no sync", hs_out, 1'b0);

        // R1, R3: directed edge timing after an end-of-active code
        cur_req = "R1/R3";
        send_code(8'hF1);
        fill(2);
        check("R3 pos begin", hs_out, 1'b0);
        fill(1);
        check("R3 pos begin+1", hs_out, 1'b1);
        fill(3);
        check("R3 pos end", hs_out, 1'b1);
        fill(1);
        check("R3 pos end+1", hs_out, 1'b0);
        fill(20 - 4 - 7);
        send_code(8'hF1);
        send_line(20);
        send_line(20);

        // R2: start-of-active code mid-line keeps the count running
        cur_req = "R2";
        fill(4);
        send_code(8'h80);
        fill(20 - 12);
        send_code(8'hF1);
        send_line(20);

        // R4: pulse across the line boundary
        cur_req = "R4";
        hs_begin = 11'd15;
        hs_end = 11'd3;
        send_line(20);
        send_line(20);
        send_line(20);

        // R5: free-running wrap without codes
        cur_req = "R5";
        hs_begin = 11'd4;
        hs_end = 11'd9;
        fill(70);

        // R6: inverted polarity
        cur_req = "R6";
        hs_invert = 1'b1;
        send_code(8'hF1);
        send_line(20);
        send_line(20);
        hs_invert = 1'b0;
        send_line(20);

        // R8: clock enable gaps with junk bytes
        cur_req = "R8";
        gap_mode = 1'b1;
        line_len = 11'd24;
        hs_begin = 11'd5;
        hs_end = 11'd12;
        send_line(24);
        send_line(24);
        send_line(24);
        send_line(24);
        gap_mode = 1'b0;

        // R9: equal edges produce no pulse
        cur_req = "R9";
        hs_begin = 11'd7;
        hs_end = 11'd7;
        send_line(24);
        send_line(24);
        check("R9 idle", hs_out, 1'b0);

        // R4: full-length line, pulse moved before the end-of-active code
        cur_req = "R4 long";
        line_len = 11'd1716;
        hs_begin = 11'd1698;
        hs_end = 11'd1710;
        send_code(8'hF1);
        send_line(1716);
        send_line(1716);

        ce = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule